// File: doc/BRIEF.md
# FIFO Block-Transfer Request Generator

This block sits beside a small word FIFO that smooths the flow of disk or display data, and tells the memory system when another block transfer should be started. It holds the FIFO storage array and two wrapping position counters. A write strobe stores a word and advances the write position. A read strobe advances the read position. The word at the read position is always visible on the read data port.

The request decision uses only where the two counters sit relative to each other, measured in groups of four entries. A transfer is requested only when both counters sit on a group boundary and the write position leads the read position by zero, one or two groups. Any other pair of positions holds the request off. The request leaves the block through a flop and is active low. A memory arbiter, which is not part of this block, watches the request and serves it.

Top module: `fifo_memreq_gen`

## Requirements
- R1: After reset both counters are 0, and the request output `mem_req_n` is 0 (asserted), because the pair (write 0, read 0) requests a transfer.
- R2: A write strobe stores `wr_data` at the current write position and increments the write counter by one, modulo 16, at that clock edge.
- R3: A read strobe increments the read counter by one, modulo 16. `rd_data` always shows the word stored at the current read position.
- R4: When the read counter is not a multiple of 4 (its two low bits are not 00), `mem_req_n` is 1.
- R5: When the write counter is not a multiple of 4, `mem_req_n` is 1.
- R6: When both counters are multiples of 4 and the write group number minus the read group number, modulo 4, is 0, 1 or 2, `mem_req_n` is 0. The group number is the counter's upper two bits. Examples: read 0 with write 0, 4 or 8; read 4 with write 4, 8 or 12; read 8 with write 8, 12 or 0; read 12 with write 12, 0 or 4.
- R7: When both counters are multiples of 4 and the write counter is one group behind the read counter (group difference 3), `mem_req_n` is 1.
- R8: `mem_req_n` is registered. It reflects the counter values of the previous clock, so it changes one clock after a counter update and stays unchanged while the counters stay unchanged.
- R9: Write and read strobes in the same cycle advance both counters at that edge. The word written in that cycle is visible on `rd_data` if the new read position points at it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe: store a word and advance the write counter |
| wr_data | input | 16 | Word to store |
| rd_en | input | 1 | Read strobe: advance the read counter |
| rd_data | output | 16 | Word at the current read position |
| mem_req_n | output | 1 | Registered block-transfer request, active low |

## Verification
A full sweep walks the write counter through all 16 positions for each of the 16 read positions. This covers all 256 counter pairs. It separates an aligned lead of 0 to 2 groups from the one-group-behind case, and it separates both from misalignment of either counter alone. During the sweep, each output is sampled once right after the counter edge and once a clock later, which shows the one-cycle register delay. A fill and drain with distinct words checks storage and read-position tracking. A run of simultaneous read and write strobes shows that both counters move together, and that a word written on the same edge can be read back at once.

// File: rtl/fifo_memreq_pkg.sv
package fifo_memreq_pkg;

  // Position-counter defaults shared by the whole block.
  localparam int unsigned POS_W_DEF   = 4;  // log2 of FIFO depth
  localparam int unsigned GROUP_W_DEF = 2;  // log2 of entries per group
  localparam int unsigned LEAD_MAX_DEF = 2; // largest group lead that requests

  typedef enum logic [1:0] {
    REQ_HOLD_RD_MISALIGNED = 2'd0,
    REQ_HOLD_WR_MISALIGNED = 2'd1,
    REQ_HOLD_BEHIND        = 2'd2,
    REQ_GRANT_WINDOW       = 2'd3
  } req_reason_e;

endpackage

// File: rtl/fifo_memreq_counter.sv
module fifo_memreq_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] next_value;

  always_comb begin
    next_value = value;
    if (step) next_value = value + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= next_value;
  end

  // R2 R3: a strobe moves the position by exactly one, modulo the depth
  p_step_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (value == $past(value) + ONE));

  // R2 R3: without a strobe the position holds
  p_hold_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(value));

endmodule

// File: rtl/fifo_memreq_store.sv
module fifo_memreq_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

  // R2: the strobed word lands at the strobed position
  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cells[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/fifo_memreq_decide.sv
module fifo_memreq_decide
  import fifo_memreq_pkg::*;
#(
  parameter int unsigned POS_W    = POS_W_DEF,
  parameter int unsigned GROUP_W  = GROUP_W_DEF,
  parameter int unsigned LEAD_MAX = LEAD_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] wr_pos,
  input  logic [POS_W-1:0] rd_pos,
  output logic             mem_req_n
);

  localparam int unsigned   QW        = POS_W - GROUP_W;
  localparam logic [QW-1:0] LEAD_LIM  = QW'(LEAD_MAX);
  localparam logic [POS_W-1:0] GROUP_STEP = POS_W'(1 << GROUP_W);

  // Classify a position pair; the request is wanted only in the grant window.
  function automatic req_reason_e classify(input logic [POS_W-1:0] w,
                                           input logic [POS_W-1:0] r);
    logic [QW-1:0] lead;
    lead = w[POS_W-1:GROUP_W] - r[POS_W-1:GROUP_W];
    if (r[GROUP_W-1:0] != '0)      return REQ_HOLD_RD_MISALIGNED;
    else if (w[GROUP_W-1:0] != '0) return REQ_HOLD_WR_MISALIGNED;
    else if (lead > LEAD_LIM)      return REQ_HOLD_BEHIND;
    else                           return REQ_GRANT_WINDOW;
  endfunction

  localparam logic RESET_REQ_N = (classify('0, '0) != REQ_GRANT_WINDOW);

  // Named internal events for the checks below.
  req_reason_e reason;
  logic        rd_on_boundary;
  logic        wr_on_boundary;
  logic        want_req;

  assign reason         = classify(wr_pos, rd_pos);
  assign rd_on_boundary = (rd_pos[GROUP_W-1:0] == '0);
  assign wr_on_boundary = (wr_pos[GROUP_W-1:0] == '0);
  assign want_req       = (reason == REQ_GRANT_WINDOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_req_n <= RESET_REQ_N;
    else        mem_req_n <= !want_req;
  end

  // R4: read position off a group boundary never requests
  p_rd_misaligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_on_boundary |=> mem_req_n);

  // R5: write position off a group boundary never requests
  p_wr_misaligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_on_boundary |=> mem_req_n);

  // R7: write one group behind read holds the request off
  p_behind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on_boundary && (wr_pos == rd_pos - GROUP_STEP)) |=> mem_req_n);

  // R6: equal aligned positions always request
  p_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on_boundary && (wr_pos == rd_pos)) |=> !mem_req_n);

  // R8: unchanged positions give an unchanged output
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(wr_pos) && $stable(rd_pos)) |=> $stable(mem_req_n));

endmodule

// File: rtl/fifo_memreq_gen.sv
module fifo_memreq_gen
  import fifo_memreq_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POS_W    = POS_W_DEF,
  parameter int unsigned GROUP_W  = GROUP_W_DEF,
  parameter int unsigned LEAD_MAX = LEAD_MAX_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req_n
);

  logic [POS_W-1:0] wr_pos;
  logic [POS_W-1:0] rd_pos;

  fifo_memreq_counter #(.W(POS_W)) u_wr_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (wr_en),
    .value (wr_pos)
  );

  fifo_memreq_counter #(.W(POS_W)) u_rd_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rd_en),
    .value (rd_pos)
  );

  fifo_memreq_store #(.DATA_W(DATA_W), .ADDR_W(POS_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_pos),
    .wr_data (wr_data),
    .rd_addr (rd_pos),
    .rd_data (rd_data)
  );

  fifo_memreq_decide #(
    .POS_W    (POS_W),
    .GROUP_W  (GROUP_W),
    .LEAD_MAX (LEAD_MAX)
  ) u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pos    (wr_pos),
    .rd_pos    (rd_pos),
    .mem_req_n (mem_req_n)
  );

  // R9: simultaneous strobes move both positions on the same edge
  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> ((wr_pos != $past(wr_pos)) && (rd_pos != $past(rd_pos))));

  // R1: right after reset the positions meet at zero
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> ((wr_pos == '0) && (rd_pos == '0)));

endmodule

// File: tb/fifo_memreq_gen_bench.sv
`timescale 1ns/1ps
module fifo_memreq_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        mem_req_n;

  int n_checks = 0;
  int n_fails  = 0;
  int w_model  = 0;
  int r_model  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  fifo_memreq_gen u_fifo_memreq_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .mem_req_n (mem_req_n)
  );

  // Expected output from the listed table (R4 R5 R6 R7), written per read position.
  function automatic logic model_req_n(input int w, input int r);
    case (r)
      0:  return !(w == 0  || w == 4  || w == 8);
      4:  return !(w == 4  || w == 8  || w == 12);
      8:  return !(w == 8  || w == 12 || w == 0);
      12: return !(w == 12 || w == 0  || w == 4);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b (w=%0d r=%0d)", req, act, exp, w_model, r_model);
    end
  endtask

  task automatic check_word(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with the given strobes; returns at the falling edge after the update.
  task automatic cycle(input bit we, input bit re, input logic [15:0] d);
    @(negedge clk);
    wr_en = we; rd_en = re; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (we) w_model = (w_model + 1) % 16;
    if (re) r_model = (r_model + 1) % 16;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    w_model = 0; r_model = 0;
    repeat (3) @(negedge clk);
    check_bit("R1 request during reset", mem_req_n, 1'b0);
    rst_n = 1'b1;
    settle();
    check_bit("R1 request after reset", mem_req_n, 1'b0);
  endtask

  task automatic t_fill_drain();
    t_reset();
    for (int i = 0; i < 16; i++) cycle(1'b1, 1'b0, 16'hA500 + 16'(i * 7));
    for (int i = 0; i < 16; i++) begin
      check_word("R3 read word", rd_data, 16'hA500 + 16'(i * 7));
      cycle(1'b0, 1'b1, '0);
    end
    check_word("R2 wrap to first entry", rd_data, 16'hA500);
  endtask

  task automatic t_sweep();
    logic prev;
    t_reset();
    for (int ri = 0; ri < 16; ri++) begin
      for (int wi = 0; wi < 16; wi++) begin
        prev = model_req_n(w_model, r_model);
        cycle(1'b1, 1'b0, 16'(wi));
        check_bit("R8 output lags counter", mem_req_n, prev);
        settle();
        if (r_model % 4 != 0)      check_bit("R4 read misaligned", mem_req_n, model_req_n(w_model, r_model));
        else if (w_model % 4 != 0) check_bit("R5 write misaligned", mem_req_n, model_req_n(w_model, r_model));
        else if (((w_model / 4 - r_model / 4) & 3) == 3)
                                   check_bit("R7 write behind", mem_req_n, model_req_n(w_model, r_model));
        else                       check_bit("R6 request window", mem_req_n, model_req_n(w_model, r_model));
      end
      cycle(1'b0, 1'b1, '0);
      settle();
      check_bit("R3 read advance", mem_req_n, model_req_n(w_model, r_model));
    end
  endtask

  task automatic t_simultaneous();
    t_reset();
    cycle(1'b1, 1'b0, 16'h1111);
    cycle(1'b1, 1'b1, 16'h2222);
    check_word("R9 same-edge word visible", rd_data, 16'h2222);
    settle();
    check_bit("R9 w2 r1", mem_req_n, 1'b1);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 16'(16'h3000 + i));
    settle();
    check_bit("R9 w5 r4", mem_req_n, 1'b1);
    check_word("R9 read position", rd_data, 16'h3002);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 16'h4444);
    settle();
    check_bit("R6 w8 r4", mem_req_n, 1'b0);
  endtask

  initial begin
    #(200000 * 5.0);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_drain();
    t_sweep();
    t_simultaneous();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule